// File: doc/BRIEF.md
# Sequential Signed 16x16 Multiplier with Sign Correction

This block multiplies two 16-bit two's-complement operands and returns their 32-bit signed product. Its datapath has one small unsigned lane multiplier, 8 x 8 by default. A control sequencer steps that multiplier through the four lane-wise partial products. Each partial product is either written into a four-lane result register or added into it.

Once the unsigned product is complete, two correction steps adjust the upper half of the result. They turn the unsigned product into the signed one. Operand B's sign is handled first, then operand A's.

A caller pulses `start_i` while the block is idle, with both operands on the inputs. It then waits for the one-cycle `done_o` pulse and reads `result_o`. The lane width is a parameter. The operand width is always two lanes and the result width is always four lanes.

Top module: `mulc_seq_signed_mul`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `done_o` is 0 and `result_o` is all zeros.
- R2: When `done_o` is high, `result_o` equals the two's-complement product of the latched operands, taken modulo 2^32. For example, -32768 x -32768 gives 32'h4000_0000 and -1 x -1 gives 32'h0000_0001.
- R3: The operands are captured on the rising edge that accepts `start_i`. Changing `a_i` or `b_i` after that edge has no effect on the product being computed.
- R4: A `start_i` pulse that arrives while a multiply is in progress is ignored. The running result is unchanged, and no second `done_o` pulse follows.
- R5: `done_o` is low until the sixth rising edge after the accepting edge. It goes high after that edge, for exactly one cycle, whatever the operand values.
- R6: After the last step, `result_o` holds its value until the first step of the next accepted multiply.
- R7: Partial products are formed in a fixed order, with lane 0 as the least significant lane. After step 1, lanes 1:0 hold A_lo x B_lo and lanes 3:2 keep their previous value. After step 2, lanes 3:2 hold A_hi x B_hi. Steps 3 and 4 add A_lo x B_hi and then A_hi x B_lo, each shifted up one lane, with the carry rippling up to lane 3. After step 4, `result_o` is the unsigned product of the two operands.
- R8: Step 5 subtracts A from lanes 3:2 when bit 15 of B is set. Step 6 subtracts B from lanes 3:2 when bit 15 of A is set. The borrow passes from lane 2 into lane 3, and any borrow out of lane 3 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a multiply when the block is idle |
| a_i | input | 16 | Operand A, two's complement |
| b_i | input | 16 | Operand B, two's complement |
| done_o | output | 1 | One-cycle pulse when the result is final |
| result_o | output | 32 | Result register; shows the intermediate values during a multiply |

## Verification
The bench builds two instances. The first uses the default 8-bit lane, giving 16-bit operands. For that instance the bench checks the intermediate result after each step against arithmetic computed in the bench, including the sign corner cases and a set of random pairs. The second uses a 3-bit lane, giving 6-bit operands. That makes every one of the 4096 operand pairs cheap to run, so the carry and borrow paths and both correction branches are covered exhaustively at a reduced width.

// File: rtl/mulc_pkg.sv
`timescale 1ns/1ps
package mulc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LL, ST_HH, ST_LH, ST_HL, ST_CB, ST_CA
  } step_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WR_LO, OP_WR_HI, OP_ADD_MID, OP_SUB_HI
  } acc_op_e;
endpackage

// File: rtl/mulc_umul.sv
`timescale 1ns/1ps
module mulc_umul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  assign p_o = (2*W)'(a_i) * (2*W)'(b_i);
endmodule

// File: rtl/mulc_lane_add.sv
`timescale 1ns/1ps
module mulc_lane_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  assign {co_o, s_o} = (W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(ci_i);
endmodule

// File: rtl/mulc_ctrl.sv
`timescale 1ns/1ps
module mulc_ctrl
  import mulc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output step_e step_o,
  output logic  busy_o,
  output logic  load_o,
  output logic  done_o
);
  step_e step_q;
  logic  done_q;

  assign load_o = start_i && (step_q == ST_IDLE);
  assign busy_o = (step_q != ST_IDLE);
  assign step_o = step_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= (step_q == ST_CA);
      case (step_q)
        ST_IDLE: if (start_i) step_q <= ST_LL;
        ST_LL:   step_q <= ST_HH;
        ST_HH:   step_q <= ST_LH;
        ST_LH:   step_q <= ST_HL;
        ST_HL:   step_q <= ST_CB;
        ST_CB:   step_q <= ST_CA;
        ST_CA:   step_q <= ST_IDLE;
        default: step_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mulc_seq_signed_mul.sv
`timescale 1ns/1ps
module mulc_seq_signed_mul
  import mulc_pkg::*;
#(
  parameter  int LANE_W = 8,
  localparam int OP_W   = 2 * LANE_W,
  localparam int RES_W  = 4 * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int N_LANES  = 4;
  localparam int PP_W     = 2 * LANE_W;
  localparam int MID_LANE = 1;
  localparam int SUB_LANE = N_LANES / 2;

  step_e   step;
  acc_op_e op;
  logic    busy, load;

  logic [OP_W-1:0]   a_q, b_q;
  logic [N_LANES-1:0][LANE_W-1:0] res_q, res_d, add_l, sum_l;
  logic [LANE_W-1:0] mul_a, mul_b;
  logic [PP_W-1:0]   pp;
  logic [OP_W-1:0]   sub_x;
  logic              inj;
  logic [N_LANES-1:0] cin, carry;
  logic              carry_top_unused;

  mulc_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .step_o (step),
    .busy_o (busy),
    .load_o (load),
    .done_o (done_o)
  );

  // operand lane select for the shared multiplier
  always_comb begin
    unique case (step)
      ST_HH:   begin mul_a = a_q[OP_W-1:LANE_W]; mul_b = b_q[OP_W-1:LANE_W]; end
      ST_LH:   begin mul_a = a_q[LANE_W-1:0];    mul_b = b_q[OP_W-1:LANE_W]; end
      ST_HL:   begin mul_a = a_q[OP_W-1:LANE_W]; mul_b = b_q[LANE_W-1:0];    end
      default: begin mul_a = a_q[LANE_W-1:0];    mul_b = b_q[LANE_W-1:0];    end
    endcase
  end

  mulc_umul #(.W(LANE_W)) u_umul (
    .a_i(mul_a),
    .b_i(mul_b),
    .p_o(pp)
  );

  always_comb begin
    case (step)
      ST_LL:        op = OP_WR_LO;
      ST_HH:        op = OP_WR_HI;
      ST_LH, ST_HL: op = OP_ADD_MID;
      ST_CB:        op = b_q[OP_W-1] ? OP_SUB_HI : OP_NONE;
      ST_CA:        op = a_q[OP_W-1] ? OP_SUB_HI : OP_NONE;
      default:      op = OP_NONE;
    endcase
  end

  assign sub_x = (step == ST_CB) ? a_q : b_q;
  assign inj   = (op == OP_SUB_HI);

  always_comb begin
    add_l = '0;
    if (op == OP_ADD_MID) begin
      add_l[MID_LANE]   = pp[LANE_W-1:0];
      add_l[MID_LANE+1] = pp[PP_W-1:LANE_W];
    end else if (op == OP_SUB_HI) begin
      // two's complement: invert here, +1 injected at SUB_LANE carry-in
      add_l[SUB_LANE]   = ~sub_x[LANE_W-1:0];
      add_l[SUB_LANE+1] = ~sub_x[OP_W-1:LANE_W];
    end
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    if (g == 0) begin : g_c0
      assign cin[g] = 1'b0;
    end else if (g == SUB_LANE) begin : g_cs
      assign cin[g] = carry[g-1] | inj;
    end else begin : g_cn
      assign cin[g] = carry[g-1];
    end
    mulc_lane_add #(.W(LANE_W)) u_add (
      .a_i (res_q[g]),
      .b_i (add_l[g]),
      .ci_i(cin[g]),
      .s_o (sum_l[g]),
      .co_o(carry[g])
    );
  end
  assign carry_top_unused = carry[N_LANES-1];

  always_comb begin
    case (op)
      OP_WR_LO:              res_d = {res_q[N_LANES-1:SUB_LANE], pp};
      OP_WR_HI:              res_d = {pp, res_q[SUB_LANE-1:0]};
      OP_ADD_MID, OP_SUB_HI: res_d = sum_l;
      default:               res_d = res_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (load) begin
        a_q <= a_i;
        b_q <= b_i;
      end
      res_q <= res_d;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/mulc_chk.sv
`timescale 1ns/1ps
module mulc_chk #(
  parameter  int LANE_W = 8,
  localparam int OP_W   = 2 * LANE_W,
  localparam int RES_W  = 4 * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic [RES_W-1:0] result_i,
  input logic [OP_W-1:0]  a_q_i,
  input logic [OP_W-1:0]  b_q_i
);
  logic [RES_W-1:0] a_x, b_x, ref_w;
  assign a_x   = {{OP_W{a_q_i[OP_W-1]}}, a_q_i};
  assign b_x   = {{OP_W{b_q_i[OP_W-1]}}, b_q_i};
  assign ref_w = a_x * b_x;

  AST_DONE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> result_i == ref_w); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R5
  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |-> ##7 done_i); // R5
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(a_q_i) && $stable(b_q_i)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(result_i)); // R6
endmodule

bind mulc_seq_signed_mul mulc_chk #(.LANE_W(LANE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy),
  .done_i  (done_o),
  .result_i(result_o),
  .a_q_i   (a_q),
  .b_q_i   (b_q)
);

// File: tb/tb_mulc_seq_signed_mul.sv
`timescale 1ns/1ps
module tb_mulc_seq_signed_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        done;
  logic [31:0] result;

  logic        start_s = 1'b0;
  logic [5:0]  as = '0, bs = '0;
  logic        done_s;
  logic [11:0] result_s;

  int checks = 0;
  int errors = 0;

  mulc_seq_signed_mul #(.LANE_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .done_o(done), .result_o(result)
  );

  mulc_seq_signed_mul #(.LANE_W(3)) dut_sm (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s),
    .a_i(as), .b_i(bs), .done_o(done_s), .result_o(result_s)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sprod(logic [15:0] x, logic [15:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    return p[31:0];
  endfunction

  task automatic run_full(logic [15:0] x, logic [15:0] y, bit disturb, bit busy_start);
    logic [31:0] prev, s1, s2, s4, s5, s6;
    prev = result;
    s1 = {prev[31:16], 16'(x[7:0] * y[7:0])};
    s2 = {16'(x[15:8] * y[15:8]), 16'(x[7:0] * y[7:0])};
    s4 = 32'(x) * 32'(y);
    s5 = s4 - (y[15] ? {x, 16'h0} : 32'h0);
    s6 = s5 - (x[15] ? {y, 16'h0} : 32'h0);
    @(posedge clk); #1;
    a = x; b = y; start = 1'b1;
    @(posedge clk); #1;                 // accepting edge
    start = 1'b0;
    if (disturb) begin a = ~x; b = x ^ 16'h5a5a; end   // R3
    for (int k = 1; k <= 7; k++) begin
      @(posedge clk); #1;
      if (k == 2 && busy_start) begin start = 1'b1; a = 16'h7fff; b = 16'h8001; end
      if (k == 3) start = 1'b0;
      if (k < 6)  chk("R5 done low before last step", {31'h0, done}, 32'h0);
      if (k == 6) chk("R5 done pulse", {31'h0, done}, 32'h1);
      if (k == 7) chk("R5 done one cycle", {31'h0, done}, 32'h0);
      if (k == 1) chk("R7 step1 low lanes", result, s1);
      if (k == 2) chk("R7 step2 high lanes", result, s2);
      if (k == 4) chk("R7 unsigned product", result, s4);
      if (k == 5) chk("R8 B sign correction", result, s5);
      if (k == 6) begin
        chk("R8 A sign correction", result, s6);
        chk("R2 signed product", result, sprod(x, y));
      end
      if (k == 7) chk("R6 result hold", result, s6);
    end
    if (busy_start) begin
      for (int k = 0; k < 8; k++) begin
        @(posedge clk); #1;
        chk("R4 no second done", {31'h0, done}, 32'h0);
        chk("R4 result unchanged", result, s6);
      end
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset done", {31'h0, done}, 32'h0);
    chk("R1 reset result", result, 32'h0);
    chk("R1 reset result small", {20'h0, result_s}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 done after release", {31'h0, done}, 32'h0);
    chk("R1 result after release", result, 32'h0);

    run_full(16'h0000, 16'h0000, 0, 0);
    run_full(16'h0001, 16'h0001, 0, 0);
    run_full(16'hffff, 16'hffff, 0, 0);
    run_full(16'h0001, 16'hffff, 0, 0);
    run_full(16'h7fff, 16'h7fff, 0, 0);
    run_full(16'h8000, 16'h8000, 0, 0);
    chk("R2 min x min", result, 32'h4000_0000);
    run_full(16'h8000, 16'h7fff, 0, 0);
    run_full(16'h7fff, 16'h8000, 0, 0);
    run_full(16'h8000, 16'h0001, 0, 0);
    run_full(16'h7fff, 16'hffff, 0, 0);
    run_full(16'h0000, 16'h8000, 0, 0);
    run_full(16'h1234, 16'hfedc, 1, 0);   // R3
    run_full(16'hc001, 16'h00ff, 0, 1);   // R4
    for (int i = 0; i < 60; i++)
      run_full(16'($urandom), 16'($urandom), (i % 3) == 0, (i % 7) == 0);

    // exhaustive sweep at 3-bit lanes (6-bit operands)
    for (int ia = 0; ia < 64; ia++) begin
      for (int ib = 0; ib < 64; ib++) begin
        int sa, sb, p;
        logic [11:0] e;
        sa = (ia >= 32) ? ia - 64 : ia;
        sb = (ib >= 32) ? ib - 64 : ib;
        p  = sa * sb;
        e  = p[11:0];
        @(posedge clk); #1;
        as = 6'(ia); bs = 6'(ib); start_s = 1'b1;
        @(posedge clk); #1;
        start_s = 1'b0;
        as = ~as;
        repeat (6) @(posedge clk);
        #1;
        chk("R5 small done", {31'h0, done_s}, 32'h1);
        chk("R2 small product", {20'h0, result_s}, {20'h0, e});
      end
    end
    finish_run();
  end
endmodule